// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A synchronous up-counter built from chained 4-bit stages. Each stage has a parallel preset, two count enables and a terminal-count flag. The stages are linked so that the whole chain behaves as one wide synchronous binary counter.

One enable, `en_par`, goes to every stage in common. The other enable, `en_trickle`, feeds the lowest stage. Each stage's terminal count drives the trickle enable of the stage above it. Only the trickle enable takes part in forming the terminal-count output, and it does so through a purely combinational path.

At a clock edge the stage acts with a fixed priority: clear first, then load, then count, then hold.

A build-time parameter picks the reset behaviour. It is either an immediate clear that also holds the counter through clock edges, or a clear taken at the next rising edge.

A second parameter turns the block into a programmable clock divider. The final terminal count reloads the preset, so `tc_out` pulses once every 2^(4·STAGES) − preset cycles.

Top module: `casc_counter_top`

## Requirements
- R1: When counting at a clock edge with `count` all ones, `count` becomes zero.
- R2: With `load_n` low and `rst_n` high at a rising edge, `count` takes `preset` whatever `en_par` and `en_trickle` are.
- R3: With `rst_n` and `load_n` high and both `en_par` and `en_trickle` high at a rising edge, `count` increases by exactly one.
- R4: With `rst_n` and `load_n` high and either enable low at a rising edge, `count` keeps its value.
- R5: With RESET_SYNC=0, a low `rst_n` drives `count` to zero at once, with no clock edge needed. `count` stays zero across edges while `rst_n` is low, and a low `load_n` does not change this.
- R6: With RESET_SYNC=1, a low `rst_n` at a rising edge sets `count` to zero. This holds even when `load_n` is low or both enables are high.
- R7: `tc_out` is high exactly when `en_trickle` is high and every bit of `count` is one. It follows `en_trickle` within the same cycle, and `en_par` has no effect on it.
- R8: An upper 4-bit stage advances only on the edge where all lower stages are at all ones and counting. For example, 0x0F counts to 0x10.
- R9: With AUTO_RELOAD=1, a rising edge at which `tc_out` is high loads `preset`. With both enables held high, `tc_out` then pulses once every 2^TOTAL_W − `preset` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear; immediate or edge-timed per RESET_SYNC |
| load_n | input | 1 | Active-low parallel load of `preset` |
| preset | input | STAGES*STAGE_W | Value loaded on a load or an automatic reload |
| en_par | input | 1 | Count enable common to all stages; does not affect `tc_out` |
| en_trickle | input | 1 | Count enable of the lowest stage; gates `tc_out` |
| count | output | STAGES*STAGE_W | Registered count value |
| tc_out | output | 1 | Terminal count of the whole chain |

## Verification
The count, load, hold and edge-timed clear results appear after exactly one register, on the first rising edge after the inputs are applied. The bench changes inputs on the falling edge and reads `count` two time units after the following rising edge.

`tc_out` and the immediate clear have no register in their path. They are read one time unit after the input changes in the middle of a cycle, before any edge can intervene.

The divider run works out its expected sequence one edge at a time: reload when the previous value was all ones, otherwise add one. That sequence is compared on every cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    ACT_CLEAR = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_STEP  = 2'd2,
    ACT_KEEP  = 2'd3
  } cnt_act_e;

  // Fixed priority: clear over load over step over keep.
  function automatic cnt_act_e pick_action(
    input logic clr,
    input logic ld,
    input logic ep,
    input logic et
  );
    if (clr)            return ACT_CLEAR;
    else if (ld)        return ACT_LOAD;
    else if (ep && et)  return ACT_STEP;
    else                return ACT_KEEP;
  endfunction

endpackage

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clr_req,
  input  logic         load_req,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] nxt
);

  cnt_act_e act;

  always_comb begin
    act = pick_action(clr_req, load_req, en_p, en_t);
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = ld_val;
      ACT_STEP:  nxt = cur + W'(1);
      default:   nxt = cur;
    endcase
  end

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage #(
  parameter int W          = 4,
  parameter bit RESET_SYNC = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         cep,
  input  logic         cet,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         tc
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         clr_edge;

  assign clr_edge = RESET_SYNC ? ~rst_n : 1'b0;

  cnt_next #(.W(W)) u_next (
    .clr_req  (clr_edge),
    .load_req (~load_n),
    .en_p     (cep),
    .en_t     (cet),
    .cur      (q_r),
    .ld_val   (d),
    .nxt      (q_nxt)
  );

  generate
    if (RESET_SYNC) begin : g_sync_clr
      always_ff @(posedge clk) begin
        q_r <= q_nxt;
      end
    end else begin : g_async_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end
    end
  endgenerate

  assign q  = q_r;
  // Carry-out is combinational in cet; cep deliberately plays no part.
  assign tc = cet & (&q_r);

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
  parameter int STAGES     = 2,
  parameter int STAGE_W    = 4,
  parameter bit RESET_SYNC = 1'b1,
  localparam int TOTAL_W   = STAGES * STAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_n,
  input  logic               en_par,
  input  logic               en_trickle,
  input  logic [TOTAL_W-1:0] preset,
  output logic [TOTAL_W-1:0] count,
  output logic               tc_final
);

  logic [STAGES:0] carry;

  assign carry[0] = en_trickle;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      cnt_stage #(
        .W          (STAGE_W),
        .RESET_SYNC (RESET_SYNC)
      ) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .cep    (en_par),
        .cet    (carry[i]),
        .d      (preset[i*STAGE_W +: STAGE_W]),
        .q      (count[i*STAGE_W +: STAGE_W]),
        .tc     (carry[i+1])
      );
    end
  endgenerate

  assign tc_final = carry[STAGES];

endmodule

// File: rtl/casc_counter_top.sv
module casc_counter_top #(
  parameter int STAGES      = 2,
  parameter int STAGE_W     = 4,
  parameter bit RESET_SYNC  = 1'b1,
  parameter bit AUTO_RELOAD = 1'b0,
  localparam int TOTAL_W    = STAGES * STAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_n,
  input  logic [TOTAL_W-1:0] preset,
  input  logic               en_par,
  input  logic               en_trickle,
  output logic [TOTAL_W-1:0] count,
  output logic               tc_out
);

  logic load_eff_n;

  generate
    if (AUTO_RELOAD) begin : g_divider
      assign load_eff_n = load_n & ~tc_out;
    end else begin : g_plain
      assign load_eff_n = load_n;
    end
  endgenerate

  cnt_chain #(
    .STAGES     (STAGES),
    .STAGE_W    (STAGE_W),
    .RESET_SYNC (RESET_SYNC)
  ) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_eff_n),
    .en_par     (en_par),
    .en_trickle (en_trickle),
    .preset     (preset),
    .count      (count),
    .tc_final   (tc_out)
  );

endmodule

// File: rtl/cnt_checker.sv
module cnt_checker #(
  parameter int W           = 8,
  parameter bit RESET_SYNC  = 1'b1,
  parameter bit AUTO_RELOAD = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_n,
  input logic [W-1:0] preset,
  input logic         en_par,
  input logic         en_trickle,
  input logic [W-1:0] count,
  input logic         tc_out
);

  logic reload_now;
  assign reload_now = AUTO_RELOAD && tc_out;

  // R2
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> count == $past(preset));

  // R3, R1 and R8: one step across the full width, wrapping at all ones
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trickle && !reload_now) |=> count == $past(count) + W'(1));

  // R4
  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_par && en_trickle)) |=> $stable(count));

  // R7
  p_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out == (en_trickle && (&count)));

  generate
    if (RESET_SYNC) begin : g_sync_chk
      // R6
      p_sclr_r6: assert property (@(posedge clk) !rst_n |=> count == '0);
    end else begin : g_async_chk
      // R5
      p_aclr_r5: assert property (@(posedge clk) !rst_n |-> count == '0);
    end
    if (AUTO_RELOAD) begin : g_reload_chk
      // R9
      p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_out |=> count == $past(preset));
    end
  endgenerate

endmodule

bind casc_counter_top cnt_checker #(
  .W           (TOTAL_W),
  .RESET_SYNC  (RESET_SYNC),
  .AUTO_RELOAD (AUTO_RELOAD)
) u_cnt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_n     (load_n),
  .preset     (preset),
  .en_par     (en_par),
  .en_trickle (en_trickle),
  .count      (count),
  .tc_out     (tc_out)
);

// File: tb/casc_counter_top_tb_top.sv
module casc_counter_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 5000;
  localparam int NV         = 14;

  // {rst_n, load_n, en_par, en_trickle, preset, expected count, expected tc}
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // 0  R6 clear
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h55, 8'h00, 1'b0}, // 1  R6 clear beats load
    {1'b1, 1'b0, 1'b0, 1'b0, 8'hFE, 8'hFE, 1'b0}, // 2  R2 load, enables low
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1}, // 3  R3 step, R7 tc high
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // 4  R1 wrap
    {1'b1, 1'b0, 1'b1, 1'b1, 8'h0E, 8'h0E, 1'b0}, // 5  R2 load beats count
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h0F, 1'b0}, // 6  R3 step, R7 low nibble only
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0}, // 7  R8 carry into upper stage
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h10, 1'b0}, // 8  R4 en_par low
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h10, 1'b0}, // 9  R4 en_trickle low
    {1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b1}, // 10 R2 load all ones
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1}, // 11 R7 en_par has no effect
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0}, // 12 R7 gated by en_trickle
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}  // 13 R1 wrap
  };

  logic       clk = 1'b0;
  int         n_total = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  logic       rst_n = 1'b0, load_n = 1'b1, en_par = 1'b0, en_trickle = 1'b0;
  logic [7:0] preset = '0;
  logic [7:0] count;
  logic       tc_out;

  logic       d_rst_n = 1'b0, d_load_n = 1'b1, d_en_par = 1'b1, d_en_trickle = 1'b1;
  logic [7:0] d_preset = 8'hFA;
  logic [7:0] d_count;
  logic       d_tc;

  always #(CLK_PERIOD/2) clk = ~clk;

  casc_counter_top #(.STAGES(2), .STAGE_W(4), .RESET_SYNC(1'b1), .AUTO_RELOAD(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .preset(preset),
    .en_par(en_par), .en_trickle(en_trickle), .count(count), .tc_out(tc_out)
  );

  casc_counter_top #(.STAGES(2), .STAGE_W(4), .RESET_SYNC(1'b0), .AUTO_RELOAD(1'b1)) dut_div_i (
    .clk(clk), .rst_n(d_rst_n), .load_n(d_load_n), .preset(d_preset),
    .en_par(d_en_par), .en_trickle(d_en_trickle), .count(d_count), .tc_out(d_tc)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG_LIMIT) begin
        n_total++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG_LIMIT);
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0] exp_d;

    // Vector walk on the edge-cleared counter
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {rst_n, load_n, en_par, en_trickle, preset} = VEC[i][20:9];
      @(posedge clk);
      #2;
      chk($sformatf("vec%0d count", i), count, VEC[i][8:1]);
      chk($sformatf("vec%0d tc R7", i), {7'd0, tc_out}, {7'd0, VEC[i][0]});
    end

    // R7: tc_out follows en_trickle inside a cycle, en_par ignored
    @(negedge clk);
    load_n = 1'b0; preset = 8'hFF;
    @(posedge clk);
    #2;
    chk("R2 load FF", count, 8'hFF);
    @(negedge clk);
    load_n = 1'b1; en_par = 1'b0; en_trickle = 1'b0;
    #1 chk("R7 tc low with en_trickle low", {7'd0, tc_out}, 8'd0);
    en_trickle = 1'b1;
    #1 chk("R7 tc rises with en_trickle", {7'd0, tc_out}, 8'd1);
    en_par = 1'b1;
    #1 chk("R7 en_par no effect", {7'd0, tc_out}, 8'd1);
    en_par = 1'b0;

    // R5: immediate clear on the divider instance
    @(negedge clk);
    d_rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2 chk("R3 async variant counts", d_count, 8'h03);
    @(negedge clk);
    #1 d_rst_n = 1'b0; d_load_n = 1'b0;
    #1 chk("R5 clear without edge", d_count, 8'h00);
    @(posedge clk);
    #2 chk("R5 held through edge and load", d_count, 8'h00);

    // R9: divider reload sequence
    @(negedge clk);
    d_rst_n = 1'b1;
    @(posedge clk);
    #2 chk("R2 divider load", d_count, 8'hFA);
    @(negedge clk);
    d_load_n = 1'b1;
    exp_d = 8'hFA;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      exp_d = (exp_d == 8'hFF) ? d_preset : exp_d + 8'd1;
      #2;
      chk($sformatf("R9 divider step %0d", k), d_count, exp_d);
      chk($sformatf("R9 divider tc %0d", k), {7'd0, d_tc}, {7'd0, exp_d == 8'hFF});
    end

    done = 1'b1;
    finish_run();
  end

endmodule